// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block turns pin-level activity on a set of general-purpose input ports into interrupt requests. Each of its 16 interrupt lines is tied to one pin index: line n listens to pin n of exactly one port, and a per-line selector field picks which port that is. The chosen pin is brought into the clock domain through a two-flop synchroniser. A small per-line level tracker then reports rising and falling transitions.

Software enables rising and falling detection separately for each line. A detected edge that is enabled latches into its own pending flag, with one flag for rising edges and one for falling edges. A per-line mask decides whether a pending line drives its request output toward the downstream interrupt distributor. A request stays asserted until software clears the flag by writing a one to it. A key that idles high and pulls low when pressed therefore shows up as a falling edge.

The per-line tracker is a two-state machine with states LVL_LOW and LVL_HIGH, which hold the last synchronised level seen on the selected pin:

- LVL_LOW goes to LVL_HIGH when the selected pin reads high. This is the "rise" transition and it flags a rising edge.
- LVL_HIGH goes to LVL_LOW when the selected pin reads low. This is the "fall" transition and it flags a falling edge.
- In a cycle where the selector field changes, the "reload" transition moves the machine to the state that matches the level of the newly selected pin. No edge is flagged in that cycle.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all enables, masks, pending flags and selector fields read zero and every request output is low.
- R2: Line n's 8-bit selector field sits in the word at address 8 + n/4, bits (n%4)*8 to (n%4)*8+7. Code k below the port count (0 to 9) selects port k. Any larger code holds the line at a constant high level, so no edge ever arises on it.
- R3: A line responds only to pin n of its currently selected port. Changes on the same pin of any other port have no effect.
- R4: The rising-enable word (address 0) and the falling-enable word (address 1) each hold one bit per line. An enabled edge sets that line's rising or falling pending flag on the third rising clock edge after the pin changes. An edge whose enable is clear sets nothing.
- R5: The mask word (address 2) holds one bit per line, where 1 means unmasked. Pending flags set whatever the mask value. The request of line n is high exactly when it has a pending flag and its mask bit is 1, and it stays high until the flag is cleared.
- R6: The rising pending word (address 3) and the falling pending word (address 4) are cleared per bit by writing 1. Writing 0 leaves a flag unchanged. The rising and falling flags of a line clear independently.
- R7: When an enabled edge and a clear of the same flag take effect on the same clock edge, the flag stays set.
- R8: Changing a line's selector field never creates an edge by itself, even when the old and new pins sit at different levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*NUM_LINES (160) | Raw port pins, port p pin n at bit p*NUM_LINES+n |
| bus_we | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_LINES (16) | Per-line interrupt requests |

## Verification
A key press on the selected port exercises the basic path, first with falling detection alone, then with both edge types, then behind a clear mask bit. Together these separate enable gating from mask gating and show the exact three-edge latency. Toggling the same pin index on ports that are not selected shows that the selector routes only the chosen port. Switching a line onto a pin at the opposite level, and selecting an out-of-range code while every port pulls low, shows that reselection is silent. A clear timed to land on the very edge that latches a new rising edge tells edge priority apart from clear priority. A write of zero to a pending word shows that only ones clear.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SEL_BASE = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RISE_EN   = 4'h0,
        ADR_FALL_EN   = 4'h1,
        ADR_MASK      = 4'h2,
        ADR_RISE_PEND = 4'h3,
        ADR_FALL_PEND = 4'h4
    } reg_addr_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Reset to the released (high) level so no edge appears at start-up.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/eirq_line.sv
`timescale 1ns/1ps
module eirq_line
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 10,
    parameter int unsigned SEL_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] lane_i,
    input  logic [SEL_W-1:0]     sel_cur_i,
    input  logic [SEL_W-1:0]     sel_nxt_i,
    input  logic                 sel_chg_i,
    output logic                 rise_o,
    output logic                 fall_o
);
    lvl_state_e state_q;
    lvl_state_e state_d;
    logic       cur_lvl;
    logic       new_lvl;

    // Port pick: codes at or above the port count read as idle high.
    always_comb begin : p_pick
        cur_lvl = 1'b1;
        new_lvl = 1'b1;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (sel_cur_i == SEL_W'(p)) cur_lvl = lane_i[p];
            if (sel_nxt_i == SEL_W'(p)) new_lvl = lane_i[p];
        end
    end

    always_comb begin : p_next
        state_d = state_q;
        if (sel_chg_i) begin
            state_d = new_lvl ? LVL_HIGH : LVL_LOW;     // reload
        end else begin
            unique case (state_q)
                LVL_LOW:  if (cur_lvl)  state_d = LVL_HIGH; // rise
                LVL_HIGH: if (!cur_lvl) state_d = LVL_LOW;  // fall
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin : p_state
        if (!rst_n) state_q <= LVL_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin : p_out
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!sel_chg_i) begin
            unique case (state_q)
                LVL_LOW:  rise_o = cur_lvl;
                LVL_HIGH: fall_o = !cur_lvl;
            endcase
        end
    end

    // R4: a line never reports both edge kinds at once
    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
    // R8: a reselection cycle reports no edge
    a_r8_silent_switch: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg_i |-> !(rise_o || fall_o));
endmodule

// File: rtl/eirq_regs.sv
`timescale 1ns/1ps
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned SEL_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]       rise_edge_i,
    input  logic [NUM_LINES-1:0]       fall_edge_i,
    output logic [NUM_LINES*SEL_W-1:0] sel_cur_o,
    output logic [NUM_LINES*SEL_W-1:0] sel_nxt_o,
    output logic [NUM_LINES-1:0]       sel_chg_o,
    output logic [NUM_LINES-1:0]       irq_o
);
    localparam int unsigned LPW = DATA_W / SEL_W;

    logic [NUM_LINES-1:0] rise_en_q, fall_en_q, mask_q;
    logic [NUM_LINES-1:0] rise_pend_q, fall_pend_q;
    logic [NUM_LINES-1:0] rise_set, fall_set, clr_rise, clr_fall;
    logic [SEL_W-1:0]     sel_q   [NUM_LINES];
    logic [SEL_W-1:0]     sel_nxt [NUM_LINES];

    assign rise_set = rise_edge_i & rise_en_q;
    assign fall_set = fall_edge_i & fall_en_q;
    assign clr_rise = (bus_we && bus_addr == ADR_RISE_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign clr_fall = (bus_we && bus_addr == ADR_FALL_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            mask_q    <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADR_RISE_EN) rise_en_q <= bus_wdata[NUM_LINES-1:0];
            if (bus_addr == ADR_FALL_EN) fall_en_q <= bus_wdata[NUM_LINES-1:0];
            if (bus_addr == ADR_MASK)    mask_q    <= bus_wdata[NUM_LINES-1:0];
        end
    end

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_pend_q <= '0;
            fall_pend_q <= '0;
        end else begin
            rise_pend_q <= (rise_pend_q & ~clr_rise) | rise_set;
            fall_pend_q <= (fall_pend_q & ~clr_fall) | fall_set;
        end
    end

    for (genvar n = 0; n < int'(NUM_LINES); n++) begin : g_sel
        localparam logic [ADDR_W-1:0] WADR = ADDR_W'(SEL_BASE + n / LPW);
        localparam int unsigned       OFF  = (n % LPW) * SEL_W;
        assign sel_nxt[n] = (bus_we && bus_addr == WADR) ? bus_wdata[OFF +: SEL_W] : sel_q[n];
        assign sel_chg_o[n] = (sel_nxt[n] != sel_q[n]);
        assign sel_cur_o[n*SEL_W +: SEL_W] = sel_q[n];
        assign sel_nxt_o[n*SEL_W +: SEL_W] = sel_nxt[n];

        // R7: an enabled edge always leaves its flag set
        a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            rise_set[n] |=> rise_pend_q[n]);
        // R6: a clear with no competing edge drops the flag
        a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_fall[n] && !fall_set[n]) |=> !fall_pend_q[n]);
        // R6: without a clear bit, a set flag survives
        a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_pend_q[n] && !clr_rise[n]) |=> rise_pend_q[n]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < int'(NUM_LINES); n++) sel_q[n] <= '0;
        end else begin
            for (int n = 0; n < int'(NUM_LINES); n++) sel_q[n] <= sel_nxt[n];
        end
    end

    assign irq_o = (rise_pend_q | fall_pend_q) & mask_q;

    always_comb begin : p_read
        bus_rdata = '0;
        case (bus_addr)
            ADR_RISE_EN:   bus_rdata[NUM_LINES-1:0] = rise_en_q;
            ADR_FALL_EN:   bus_rdata[NUM_LINES-1:0] = fall_en_q;
            ADR_MASK:      bus_rdata[NUM_LINES-1:0] = mask_q;
            ADR_RISE_PEND: bus_rdata[NUM_LINES-1:0] = rise_pend_q;
            ADR_FALL_PEND: bus_rdata[NUM_LINES-1:0] = fall_pend_q;
            default: begin
                for (int n = 0; n < int'(NUM_LINES); n++) begin
                    if (bus_addr == ADDR_W'(SEL_BASE + n / LPW))
                        bus_rdata[(n % LPW) * SEL_W +: SEL_W] = sel_q[n];
                end
            end
        endcase
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 10,
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned SEL_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_LINES-1:0]           irq_o
);
    localparam int unsigned NPINS = NUM_PORTS * NUM_LINES;

    logic [NPINS-1:0]           pins_s;
    logic [NUM_LINES-1:0]       rise_edge, fall_edge, sel_chg;
    logic [NUM_LINES*SEL_W-1:0] sel_cur, sel_nxt;

    eirq_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pins_i),
        .sync_o (pins_s)
    );

    for (genvar n = 0; n < int'(NUM_LINES); n++) begin : g_line
        logic [NUM_PORTS-1:0] lane;
        for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_lane
            assign lane[p] = pins_s[p*NUM_LINES + n];
        end

        eirq_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_i    (lane),
            .sel_cur_i (sel_cur[n*SEL_W +: SEL_W]),
            .sel_nxt_i (sel_nxt[n*SEL_W +: SEL_W]),
            .sel_chg_i (sel_chg[n]),
            .rise_o    (rise_edge[n]),
            .fall_o    (fall_edge[n])
        );

        // R5: a raised request holds while no register write occurs
        a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[n] && !bus_we) |=> irq_o[n]);
    end

    eirq_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .rise_edge_i (rise_edge),
        .fall_edge_i (fall_edge),
        .sel_cur_o   (sel_cur),
        .sel_nxt_o   (sel_nxt),
        .sel_chg_o   (sel_chg),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/10ps
module edge_irq_ctrl_test;
    localparam int NP = 10;
    localparam int NL = 16;
    localparam logic [3:0] A_RE = 4'h0, A_FE = 4'h1, A_MK = 4'h2, A_RP = 4'h3, A_FP = 4'h4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NL-1:0]  pins = '1;
    logic              bus_we = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NL-1:0]     irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { string tag; bit is_reg; logic [31:0] exp; } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    edge_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares with the live outputs.
    initial forever begin
        wait (sb_q.size() > 0);
        #0.1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_reg ? bus_rdata : 32'(irq_o);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_pin(input int p, input int n, input logic v);
        pins[p*NL + n] = v;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic exp_irq(input string tag, input logic [31:0] v);
        sb_q.push_back('{tag, 1'b0, v});
        #0.2;
    endtask

    task automatic exp_reg(input string tag, input logic [3:0] a, input logic [31:0] v);
        bus_addr = a;
        sb_q.push_back('{tag, 1'b1, v});
        #0.2;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        exp_irq("R1 irq after reset", 0);
        exp_reg("R1 rise enable", A_RE, 0);
        exp_reg("R1 mask", A_MK, 0);
        exp_reg("R1 rise pending", A_RP, 0);
        exp_reg("R1 selector word 0", 4'h8, 0);

        // R2 field position, R4 key press on port 5 line 9
        wr(4'hA, 32'h0000_0500);
        exp_reg("R2 line 9 field readback", 4'hA, 32'h0000_0500);
        wr(A_FE, 32'h200);
        wr(A_MK, 32'h200);
        set_pin(5, 9, 0);
        step(2);
        exp_irq("R4 not yet after two edges", 0);
        step(1);
        exp_irq("R4 falling edge after three edges", 32'h200);
        exp_reg("R4 falling pending", A_FP, 32'h200);
        exp_reg("R4 no rising pending", A_RP, 0);
        set_pin(5, 9, 1);
        step(4);
        exp_reg("R4 disabled rising ignored", A_RP, 0);
        exp_irq("R5 request held", 32'h200);

        // R6 write-zero and write-one
        wr(A_FP, 32'h0);
        exp_reg("R6 zero write keeps flag", A_FP, 32'h200);
        wr(A_FP, 32'h200);
        exp_irq("R6 write one clears", 0);
        exp_reg("R6 pending cleared", A_FP, 0);

        // R3 unselected ports ignored
        set_pin(0, 9, 0);
        step(4);
        exp_irq("R3 port 0 ignored", 0);
        set_pin(0, 9, 1);
        set_pin(3, 9, 0);
        step(4);
        exp_irq("R3 port 3 ignored", 0);

        // R8 switching to a low pin is silent
        wr(4'hA, 32'h0000_0300);
        step(4);
        exp_reg("R8 no pending from switch", A_FP, 0);
        exp_irq("R8 no request from switch", 0);
        set_pin(3, 9, 1);
        step(4);
        set_pin(3, 9, 0);
        step(3);
        exp_irq("R3 new port followed", 32'h200);
        wr(A_FP, 32'h200);
        set_pin(3, 9, 1);
        step(4);

        // R5 masked line latches but does not request
        wr(A_RE, 32'h4);
        set_pin(0, 2, 0);
        step(4);
        set_pin(0, 2, 1);
        step(3);
        exp_irq("R5 masked line quiet", 0);
        exp_reg("R5 pending despite mask", A_RP, 32'h4);
        wr(A_MK, 32'h204);
        exp_irq("R5 unmask raises request", 32'h4);

        // R7 edge and clear on the same clock edge
        set_pin(0, 2, 0);
        step(4);
        set_pin(0, 2, 1);
        step(1);
        wr(A_RP, 32'h4);
        exp_reg("R7 edge beats clear", A_RP, 32'h4);
        exp_irq("R7 request stays", 32'h4);
        wr(A_RP, 32'h4);
        exp_reg("R6 plain clear", A_RP, 0);

        // R4 both edges, R6 independent clears
        wr(A_RE, 32'h24);
        wr(A_FE, 32'h220);
        wr(A_MK, 32'h224);
        set_pin(0, 5, 0);
        step(4);
        set_pin(0, 5, 1);
        step(4);
        exp_reg("R4 both rising", A_RP, 32'h20);
        exp_reg("R4 both falling", A_FP, 32'h20);
        wr(A_RP, 32'h20);
        exp_reg("R6 rising cleared alone", A_RP, 0);
        exp_reg("R6 falling kept", A_FP, 32'h20);
        exp_irq("R6 request from falling", 32'h20);
        wr(A_FP, 32'h20);
        exp_irq("R6 both cleared", 0);

        // R2 out-of-range code and top field
        wr(4'h8, 32'h0000_000C);
        exp_reg("R2 code 12 readback", 4'h8, 32'h0000_000C);
        wr(A_FE, 32'h8221);
        wr(A_MK, 32'h8225);
        for (int p = 0; p < NP; p++) set_pin(p, 0, 0);
        step(4);
        exp_irq("R2 unused code holds high", 0);
        exp_reg("R2 no falling pending", A_FP, 0);
        for (int p = 0; p < NP; p++) set_pin(p, 0, 1);
        step(4);
        wr(4'hB, 32'h0700_0000);
        exp_reg("R2 line 15 field readback", 4'hB, 32'h0700_0000);
        set_pin(7, 15, 0);
        step(3);
        exp_irq("R2 line 15 on port 7", 32'h8000);
        exp_reg("R2 line 15 pending", A_FP, 32'h8000);

        step(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule